// File: doc/BRIEF.md
# Power-Up Reset Release Sequencer

This block keeps a device in reset after power-on until its supply and its clock can be trusted. It chains up to three waits. The first is an optional fixed supply-settling timer. The second is a start-up count of raw crystal oscillator edges. The third is an extra wait so that a frequency-multiplying PLL can lock. A short core-ready wait runs alongside the chain and does not add to it. The configured oscillator mode selects which waits take part. Once every wait that applies has finished, the block raises a single release output.

Two delays are counted on a fixed-frequency reference clock: the supply timer and the PLL lock wait. The core-ready wait is counted there as well. The crystal count runs on the raw oscillator clock itself. Its start request and its done flag cross between the two clock domains through a four-phase handshake, so a power-on pulse of any width restarts the count cleanly. The mode and the timer enable are captured while power-on reset is asserted and then held.

Top module: `pwrup_release_seq`

## Requirements
- R1: While `por_n` is low, `rst_release` reads low after the next reference edge, and all counters and the sequence return to their start; a later rising `por_n` starts the whole sequence again.
- R2: `osc_mode` encodes 0 = low-power crystal, 1 = standard crystal, 2 = high-speed crystal, 3 = high-speed crystal with PLL, 4 = external clock, 5 = RC, 6 = internal oscillator, 7 = reserved (treated like 6). `osc_mode` and `pwrt_en` are sampled only while `por_n` is low; changes made afterwards have no effect until the next power-on pulse.
- R3: A core-ready wait of `CORE_CYCLES` reference cycles starts when `por_n` rises and runs in parallel with the other waits; `rst_release` never rises before it ends.
- R4: When `pwrt_en` is captured high, a supply timer of `PWRT_CYCLES` reference cycles runs first in the chain; when it is captured low, this wait is skipped.
- R5: In the four crystal modes (0 to 3), after the supply timer the block counts `OST_CYCLES` rising edges of `osc_clk` before it allows release.
- R6: In mode 3 only, a further `PLL_CYCLES` reference cycles are waited after the crystal count.
- R7: In modes 4 to 7, no crystal count and no PLL wait take place, and `osc_clk` may be stopped without delaying release.
- R8: Once high, `rst_release` stays high until `por_n` goes low again.
- R9: Counting the first reference edge that samples `por_n` high as edge 1, in modes 4 to 7 `rst_release` first reads high after edge max(`CORE_CYCLES`+1, 2) with the supply timer disabled, and after edge max(`CORE_CYCLES`+1, `PWRT_CYCLES`+2) with it enabled.
- R10: A power-on pulse only one reference cycle wide, arriving in the middle of the crystal count, still restarts a full crystal count of `OST_CYCLES` oscillator edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fixed-frequency reference clock |
| por_n | input | 1 | Power-on reset, active low, synchronous to `clk_ref` |
| osc_mode | input | 3 | Configured oscillator mode (encoding in R2) |
| pwrt_en | input | 1 | Enables the supply-settling timer |
| osc_clk | input | 1 | Raw oscillator clock counted by the crystal start-up timer |
| rst_release | output | 1 | High once every applicable wait has finished |

## Verification
On every cycle, the assertions hold several properties. Release is sticky and never precedes the core-ready wait or the end of the chain. The PLL state is visited only in mode 3, and the crystal states only in crystal modes. The captured mode stays unchanged between power-on pulses. The counters stay inside their ranges, and their done flags hold. Only the bench's scenarios can show the absolute release latency of each mode with and without the supply timer. They also show that the oscillator clock can be stopped in the non-crystal modes, and that late changes to the mode or the enable are ignored. Finally, they show that a one-cycle power-on pulse in the middle of the crystal count still causes a full recount across the clock-domain handshake.

// File: rtl/pwrup_pkg.sv
// Package: shared encodings for the power-up release sequencer.
// Assumes a 3-bit oscillator mode field whose code values are fixed by R2.
package pwrup_pkg;

    typedef enum logic [2:0] {
        OSC_LP    = 3'd0,
        OSC_XT    = 3'd1,
        OSC_HS    = 3'd2,
        OSC_HSPLL = 3'd3,
        OSC_EC    = 3'd4,
        OSC_RC    = 3'd5,
        OSC_INT   = 3'd6,
        OSC_RSVD  = 3'd7
    } osc_mode_e;

    typedef enum logic [2:0] {
        ST_PWRT   = 3'd0,
        ST_OSTCLR = 3'd1,
        ST_OST    = 3'd2,
        ST_PLL    = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    // True for the modes that drive a crystal and so need the start-up count.
    function automatic logic is_crystal(osc_mode_e m);
        return (m == OSC_LP) || (m == OSC_XT) || (m == OSC_HS) || (m == OSC_HSPLL);
    endfunction

endpackage

// File: rtl/bit_sync.sv
// Module: multi-flop synchronizer for one level signal.
// Assumes the input is a registered level from another domain; STAGES >= 2.
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ref_delay_cnt.sv
// Module: one-shot delay counter in the reference domain.
// Counts LEN cycles in which run_i is high, then holds done_o until rst_n drops.
// Assumes LEN >= 2.
module ref_delay_cnt #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Advance while running; flag completion on the LEN-th counted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (run_i && !done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done_o = done_q;

    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/osc_startup_cnt.sv
// Module: crystal start-up counter clocked by the raw oscillator.
// Counts OST_CYCLES oscillator edges once the start request (from the
// reference domain) is seen high; clears count and done while it is low.
// Assumes start_a is a registered level and OST_CYCLES >= 2.
module osc_startup_cnt #(
    parameter int OST_CYCLES = 1024
) (
    input  logic osc_clk,
    input  logic start_a,
    output logic done_o
);
    localparam int CW = $clog2(OST_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    logic          start_s;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    bit_sync #(.STAGES(2)) u_start_sync (
        .clk   (osc_clk),
        .rst_n (1'b1),
        .d     (start_a),
        .q     (start_s)
    );

    // Count oscillator edges while requested; a low request acts as reset.
    always_ff @(posedge osc_clk) begin
        if (!start_s) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done_o = done_q;

    p_ost_done_hold_r5: assert property (@(posedge osc_clk) disable iff (!start_s)
        done_q |=> done_q);
    p_ost_cnt_range_r5: assert property (@(posedge osc_clk) disable iff (!start_s)
        cnt_q <= LAST);
endmodule

// File: rtl/pwrup_release_seq.sv
// Module: power-up reset release sequencer (top).
// Chains supply timer -> crystal start-up count -> PLL lock wait, chosen by
// the captured oscillator mode, with a core-ready wait in parallel. Release
// rises when all applicable waits are done and stays high until por_n drops.
// Assumes por_n is synchronous to clk_ref; osc_clk is unrelated to clk_ref.
module pwrup_release_seq
    import pwrup_pkg::*;
#(
    parameter int CORE_CYCLES = 10,
    parameter int PWRT_CYCLES = 65536,
    parameter int OST_CYCLES  = 1024,
    parameter int PLL_CYCLES  = 2000
) (
    input  logic       clk_ref,
    input  logic       por_n,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_en,
    input  logic       osc_clk,
    output logic       rst_release
);
    osc_mode_e  mode_q;
    logic       pwrt_en_q;
    seq_state_e state_q;
    logic       ost_start_q;
    logic       release_q;

    logic core_done;
    logic pwrt_done;
    logic pll_done;
    logic ost_done_raw;
    logic ost_done_s;

    // Capture the configuration while power-on reset is held.
    always_ff @(posedge clk_ref) begin
        if (!por_n) begin
            mode_q    <= osc_mode_e'(osc_mode);
            pwrt_en_q <= pwrt_en;
        end
    end

    ref_delay_cnt #(.LEN(CORE_CYCLES)) u_core_cnt (
        .clk    (clk_ref),
        .rst_n  (por_n),
        .run_i  (1'b1),
        .done_o (core_done)
    );

    ref_delay_cnt #(.LEN(PWRT_CYCLES)) u_pwrt_cnt (
        .clk    (clk_ref),
        .rst_n  (por_n),
        .run_i  ((state_q == ST_PWRT) && pwrt_en_q),
        .done_o (pwrt_done)
    );

    ref_delay_cnt #(.LEN(PLL_CYCLES)) u_pll_cnt (
        .clk    (clk_ref),
        .rst_n  (por_n),
        .run_i  (state_q == ST_PLL),
        .done_o (pll_done)
    );

    osc_startup_cnt #(.OST_CYCLES(OST_CYCLES)) u_ost_cnt (
        .osc_clk (osc_clk),
        .start_a (ost_start_q),
        .done_o  (ost_done_raw)
    );

    bit_sync #(.STAGES(2)) u_ost_done_sync (
        .clk   (clk_ref),
        .rst_n (1'b1),
        .d     (ost_done_raw),
        .q     (ost_done_s)
    );

    // Step through the delay chain selected by the captured mode.
    always_ff @(posedge clk_ref) begin
        if (!por_n) begin
            state_q     <= ST_PWRT;
            ost_start_q <= 1'b0;
        end else begin
            case (state_q)
                ST_PWRT: begin
                    if (!pwrt_en_q || pwrt_done)
                        state_q <= is_crystal(mode_q) ? ST_OSTCLR : ST_DONE;
                end
                ST_OSTCLR: begin
                    // Wait for a stale done flag from a previous run to clear.
                    if (!ost_done_s) begin
                        state_q     <= ST_OST;
                        ost_start_q <= 1'b1;
                    end
                end
                ST_OST: begin
                    if (ost_done_s)
                        state_q <= (mode_q == OSC_HSPLL) ? ST_PLL : ST_DONE;
                end
                ST_PLL: begin
                    if (pll_done) state_q <= ST_DONE;
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    // Raise release once the chain and the core-ready wait are both done.
    always_ff @(posedge clk_ref) begin
        if (!por_n) release_q <= 1'b0;
        else        release_q <= release_q | ((state_q == ST_DONE) && core_done);
    end

    assign rst_release = release_q;

    p_release_sticky_r8: assert property (@(posedge clk_ref) disable iff (!por_n)
        rst_release |=> rst_release);
    p_release_after_core_r3: assert property (@(posedge clk_ref) disable iff (!por_n)
        rst_release |-> core_done);
    p_release_chain_end_r5: assert property (@(posedge clk_ref) disable iff (!por_n)
        rst_release |-> (state_q == ST_DONE));
    p_pll_only_mode3_r6: assert property (@(posedge clk_ref) disable iff (!por_n)
        (state_q == ST_PLL) |-> (mode_q == OSC_HSPLL));
    p_ost_only_crystal_r7: assert property (@(posedge clk_ref) disable iff (!por_n)
        ((state_q == ST_OSTCLR) || (state_q == ST_OST)) |-> is_crystal(mode_q));
    p_mode_held_r2: assert property (@(posedge clk_ref) disable iff (!por_n)
        por_n |=> ($stable(mode_q) && $stable(pwrt_en_q)));
endmodule

// File: tb/pwrup_release_seq_bench.sv
// Bench: directed scenarios, one task each, for the power-up release sequencer.
module pwrup_release_seq_bench;
    localparam int CORE = 8;
    localparam int PWRT = 40;
    localparam int PLL  = 30;
    localparam int OST  = 1024;
    // Oscillator period 6 ns, reference period 10 ns: OST edges >= 614 ref cycles.
    localparam int OST_REF = (OST * 6) / 10;
    localparam int SLACK   = 20;
    localparam int LIMIT   = 5000;

    logic       clk_ref = 1'b0;
    logic       osc_clk = 1'b0;
    logic       osc_run = 1'b1;
    logic       por_n   = 1'b0;
    logic [2:0] osc_mode = 3'd4;
    logic       pwrt_en  = 1'b0;
    logic       rst_release;

    int checks = 0;
    int fails  = 0;

    always #5 clk_ref = ~clk_ref;
    always begin
        #3;
        if (osc_run) osc_clk = ~osc_clk;
    end

    pwrup_release_seq #(
        .CORE_CYCLES (CORE),
        .PWRT_CYCLES (PWRT),
        .OST_CYCLES  (OST),
        .PLL_CYCLES  (PLL)
    ) u_pwrup_release_seq (
        .clk_ref     (clk_ref),
        .por_n       (por_n),
        .osc_mode    (osc_mode),
        .pwrt_en     (pwrt_en),
        .osc_clk     (osc_clk),
        .rst_release (rst_release)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Hold por low for len cycles with the given configuration, then release it.
    task automatic do_por(input logic [2:0] m, input logic en, input int len);
        @(negedge clk_ref);
        por_n    = 1'b0;
        osc_mode = m;
        pwrt_en  = en;
        repeat (len) @(negedge clk_ref);
        por_n = 1'b1;
    endtask

    // Count reference edges until release reads high.
    task automatic measure(output int n);
        n = 0;
        while (!rst_release && n < LIMIT) begin
            @(negedge clk_ref);
            n++;
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic t_reset();
        @(negedge clk_ref);
        por_n = 1'b0;
        @(negedge clk_ref);
        chk(rst_release == 1'b0, "R1 low one edge into por", rst_release, 0);
        repeat (5) @(negedge clk_ref);
        chk(rst_release == 1'b0, "R1 low while por held", rst_release, 0);
    endtask

    task automatic t_exact(input logic [2:0] m, input logic en, input string req);
        int n;
        int exp;
        do_por(m, en, 10);
        measure(n);
        exp = en ? imax(CORE + 1, PWRT + 2) : imax(CORE + 1, 2);
        chk(n == exp, req, n, exp);
    endtask

    task automatic t_ec_no_osc();
        int n;
        osc_run = 1'b0;
        do_por(3'd4, 1'b0, 10);
        measure(n);
        chk(n == CORE + 1, "R7 R3 R9 mode 4 with osc stopped", n, CORE + 1);
        osc_run = 1'b1;
    endtask

    task automatic t_crystal(input logic [2:0] m, input logic en, input string req);
        int n;
        int lo;
        do_por(m, en, 10);
        measure(n);
        lo = (en ? PWRT + 1 : 1) + OST_REF + ((m == 3'd3) ? PLL + 1 : 0);
        chk(n >= lo && n <= lo + SLACK, req, n, lo);
    endtask

    task automatic t_mode_ignored();
        int n;
        do_por(3'd1, 1'b0, 10);
        osc_mode = 3'd4;
        pwrt_en  = 1'b1;
        measure(n);
        chk(n >= 1 + OST_REF && n <= 1 + OST_REF + SLACK,
            "R2 late mode/enable change ignored", n, 1 + OST_REF);
    endtask

    task automatic t_sticky();
        int drops = 0;
        do_por(3'd5, 1'b0, 10);
        repeat (CORE + 4) @(negedge clk_ref);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk_ref);
            if (!rst_release) drops++;
        end
        chk(drops == 0, "R8 release held high", drops, 0);
    endtask

    task automatic t_short_pulse();
        int n;
        do_por(3'd2, 1'b0, 10);
        repeat (300) @(negedge clk_ref);
        chk(rst_release == 1'b0, "R5 still counting mid-crystal", rst_release, 0);
        por_n = 1'b0;
        @(negedge clk_ref);
        por_n = 1'b1;
        chk(rst_release == 1'b0, "R1 short pulse drops release", rst_release, 0);
        measure(n);
        chk(n >= 1 + OST_REF && n <= 1 + OST_REF + SLACK,
            "R10 full recount after short pulse", n, 1 + OST_REF);
    endtask

    initial begin
        repeat (150000) @(posedge clk_ref);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_exact(3'd4, 1'b0, "R9 R3 mode 4 no supply timer");
        t_exact(3'd5, 1'b1, "R4 R9 mode 5 with supply timer");
        t_exact(3'd6, 1'b1, "R4 R7 mode 6 with supply timer");
        t_exact(3'd7, 1'b0, "R2 R7 reserved mode 7");
        t_ec_no_osc();
        t_crystal(3'd0, 1'b0, "R5 mode 0 crystal count");
        t_crystal(3'd1, 1'b1, "R5 R4 mode 1 supply then crystal");
        t_crystal(3'd2, 1'b0, "R5 mode 2 crystal count");
        t_crystal(3'd3, 1'b0, "R6 mode 3 crystal plus PLL");
        t_crystal(3'd3, 1'b1, "R6 R4 mode 3 all waits");
        t_mode_ignored();
        t_sticky();
        t_short_pulse();
        t_reset();
        summary();
        $finish;
    end
endmodule